// File: doc/BRIEF.md
# Clock-loss power mode controller

This block decides which parts of a converter's digital core receive power. It watches a master clock from a separate free-running reference clock. If the master clock has no edge for a programmable timeout, the block flags the clock as lost. It combines that flag with an active-low power-down pin, a power-enable control bit, a core-run control bit (the soft reset, where 0 holds the core in reset) and a pin that keeps the regulator alive. From these inputs it drives registered enables for the digital block, the analog block, the regulator, the register file and the reference current. It also drives a zero-detect enable and a two-bit analog output mode.

Each master clock rising edge flips a toggle flop. The toggle is synchronized into the reference domain, and every change of the synchronized value restarts a timeout counter. The master clock therefore acts as a power control of its own. When it stops, everything except an optionally held regulator is switched off. When a set number of edges arrives again with gaps shorter than the timeout, the block returns to the mode that the control bits select. This needs no power-down pin cycle and no power-on sequence. The power-down pin overrides every other input and clears all outputs asynchronously.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While `pdn_n` is 0, all enables are 0 and `aout_mode` is 0 (high impedance), independent of all other inputs; the clearing takes effect asynchronously, without waiting for a `ref_clk` edge.
- R2: With `pdn_n` high, the clock is declared lost exactly `TIMEOUT_CYC` reference cycles after the last detected toggle change (default 50, which is 1 µs at a 50 MHz reference). Measured from the moment the master clock stops, the outputs leave their running values within `TIMEOUT_CYC` to `TIMEOUT_CYC`+8 reference cycles.
- R3: In the clock-stop state, `dig_en`, `ana_en`, `reg_en`, `iref_en` and `zdet_en` are 0 and `aout_mode` is 0, whatever `pwr_en` and `core_run` are.
- R4: In the clock-stop state, `ldo_en` equals `ldo_keep`.
- R5: Clock present and `pwr_en`=0: `dig_en`=0, `ana_en`=0, `ldo_en`=1, `reg_en`=1, `iref_en`=1, `zdet_en`=1, `aout_mode`=0.
- R6: Clock present, `pwr_en`=1 and `core_run`=0: `dig_en`=0, `ana_en`=1, `ldo_en`=1, `reg_en`=1, `iref_en`=1, `zdet_en`=1, `aout_mode`=1 (common-mode level).
- R7: Clock present, `pwr_en`=1 and `core_run`=1: every enable is 1 and `aout_mode`=2 (signal).
- R8: The clock-stop state is left only after `RESUME_EDGES` consecutive master clock edges; fewer edges leave the outputs in the clock-stop values. Leaving it needs no `pdn_n` cycle.
- R9: A gap of `TIMEOUT_CYC` reference cycles without an edge, while the clock is lost, discards the edges counted so far toward resuming.
- R10: After `pdn_n` rises, the block starts in the clock-stop state and stays there until R8 is satisfied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all outputs are registered on it |
| pdn_n | input | 1 | Power-down pin, active low, asynchronous, highest priority |
| mclk | input | 1 | Master clock being watched |
| ldo_keep | input | 1 | Keeps the regulator enabled during clock stop |
| pwr_en | input | 1 | Power-enable control bit (reference domain) |
| core_run | input | 1 | Soft reset bit, 1 releases the digital core (reference domain) |
| dig_en | output | 1 | Digital block enable |
| ana_en | output | 1 | Analog block enable |
| ldo_en | output | 1 | Regulator enable |
| reg_en | output | 1 | Register file enable |
| iref_en | output | 1 | Reference current enable |
| zdet_en | output | 1 | Zero-detect enable |
| aout_mode | output | 2 | Analog output mode: 0 high impedance, 1 common-mode, 2 signal |

## Verification
The bench builds the block with `TIMEOUT_CYC`=20, `RESUME_EDGES`=3 and two synchronizer stages. These values make a timeout take a few hundred nanoseconds, so it can run the full 32-point sweep over pin, clock-running and control-bit combinations, with a settle time of several timeouts at each point. They also keep edge counts of two and three short enough to show both a resume that falls one edge short and one that succeeds. The small timeout lets the stop-to-off latency be measured cycle by cycle against its window, and lets a gap longer than the timeout be inserted between edge bursts.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

   typedef enum logic [1:0] {
      AOUT_HIZ = 2'd0,
      AOUT_VCM = 2'd1,
      AOUT_SIG = 2'd2
   } aout_mode_t;

   typedef enum logic [2:0] {
      PM_OFF     = 3'd0,
      PM_CLKSTOP = 3'd1,
      PM_STANDBY = 3'd2,
      PM_BIAS    = 3'd3,
      PM_RUN     = 3'd4
   } pm_mode_t;

   typedef struct packed {
      logic       dig;
      logic       ana;
      logic       ldo;
      logic       regf;
      logic       iref;
      logic       zdet;
      aout_mode_t aout;
   } pm_out_t;

   localparam pm_out_t PM_ALL_OFF = '{dig: 1'b0, ana: 1'b0, ldo: 1'b0, regf: 1'b0,
                                      iref: 1'b0, zdet: 1'b0, aout: AOUT_HIZ};

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pm_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= '0;
      else         q <= {q[STAGES-2:0], 1'b1};
   end

   assign rst_n = q[STAGES-1];
endmodule

// File: rtl/pm_mclk_toggle.sv
module pm_mclk_toggle (
   input  logic mclk,
   input  logic arst_n,
   output logic tgl
);
   always_ff @(posedge mclk or negedge arst_n) begin
      if (!arst_n) tgl <= 1'b0;
      else         tgl <= ~tgl;
   end
endmodule

// File: rtl/pm_clk_watch.sv
module pm_clk_watch #(
   parameter int SYNC_STAGES  = 2,
   parameter int TIMEOUT_CYC  = 50,
   parameter int RESUME_EDGES = 4
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic tgl_async,
   output logic clk_lost
);
   localparam int CW = $clog2(TIMEOUT_CYC + 1);
   localparam int RW = $clog2(RESUME_EDGES + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);
   localparam logic [RW-1:0] RES_LAST = RW'(RESUME_EDGES - 1);

   generate
      if (TIMEOUT_CYC < 4) begin : g_bad_timeout
         $error("pm_clk_watch: TIMEOUT_CYC must be at least 4");
      end
      if (RESUME_EDGES < 1) begin : g_bad_resume
         $error("pm_clk_watch: RESUME_EDGES must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sq;
   logic                   s_prev;
   logic                   chg;
   logic [CW-1:0]          cnt;
   logic [RW-1:0]          res_cnt;
   logic                   timed_out;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge ref_clk or negedge rst_n) begin
               if (!rst_n) sq[0] <= 1'b0;
               else        sq[0] <= tgl_async;
            end
         end else begin : g_next
            always_ff @(posedge ref_clk or negedge rst_n) begin
               if (!rst_n) sq[i] <= 1'b0;
               else        sq[i] <= sq[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= sq[SYNC_STAGES-1];
   end

   assign chg       = sq[SYNC_STAGES-1] ^ s_prev;
   assign timed_out = (cnt == CNT_LAST) && !chg;

   // quiet-time counter, saturating one short of the timeout
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (chg)             cnt <= '0;
      else if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
   end

   // lost flag and resume edge counter
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_lost <= 1'b1;
         res_cnt  <= '0;
      end else if (!clk_lost) begin
         res_cnt <= '0;
         if (timed_out) clk_lost <= 1'b1;
      end else begin
         if (timed_out) begin
            res_cnt <= '0;
         end else if (chg) begin
            if (res_cnt == RES_LAST) begin
               clk_lost <= 1'b0;
               res_cnt  <= '0;
            end else begin
               res_cnt <= res_cnt + 1'b1;
            end
         end
      end
   end

   // R2: the lost flag only rises after a full quiet window
   p_lost_after_quiet_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(clk_lost) |-> ($past(cnt) == CNT_LAST) && !$past(chg));

   // R8: resuming takes the configured number of edges
   p_resume_after_edges_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(clk_lost) |-> ($past(res_cnt) == RES_LAST) && $past(chg));

   // R9: a quiet window while lost discards partial progress
   p_gap_clears_count_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (clk_lost && timed_out) |=> (res_cnt == '0) && clk_lost);

endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
   import pwrmode_pkg::*;
(
   input  logic    ref_clk,
   input  logic    rst_n,
   input  logic    clk_lost,
   input  logic    pwr_en,
   input  logic    core_run,
   input  logic    ldo_keep,
   output pm_out_t outs
);
   pm_mode_t mode;
   pm_out_t  nxt;

   always_comb begin
      if (clk_lost)     mode = PM_CLKSTOP;
      else if (!pwr_en) mode = PM_STANDBY;
      else if (!core_run) mode = PM_BIAS;
      else              mode = PM_RUN;
   end

   always_comb begin
      nxt = PM_ALL_OFF;
      case (mode)
         PM_CLKSTOP: begin
            nxt.ldo = ldo_keep;
         end
         PM_STANDBY: begin
            nxt.ldo  = 1'b1;
            nxt.regf = 1'b1;
            nxt.iref = 1'b1;
            nxt.zdet = 1'b1;
         end
         PM_BIAS: begin
            nxt.ana  = 1'b1;
            nxt.ldo  = 1'b1;
            nxt.regf = 1'b1;
            nxt.iref = 1'b1;
            nxt.zdet = 1'b1;
            nxt.aout = AOUT_VCM;
         end
         PM_RUN: begin
            nxt.dig  = 1'b1;
            nxt.ana  = 1'b1;
            nxt.ldo  = 1'b1;
            nxt.regf = 1'b1;
            nxt.iref = 1'b1;
            nxt.zdet = 1'b1;
            nxt.aout = AOUT_SIG;
         end
         default: nxt = PM_ALL_OFF;
      endcase
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) outs <= PM_ALL_OFF;
      else        outs <= nxt;
   end

   // R3: a lost clock turns off the core, the registers and zero detect
   p_stop_outputs_off_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      clk_lost |=> !outs.dig && !outs.ana && !outs.regf && !outs.zdet
                   && (outs.aout == AOUT_HIZ));

   // R4: the regulator follows the keep pin during clock stop
   p_stop_ldo_keep_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      clk_lost |=> (outs.ldo == $past(ldo_keep)));

   // R7: signal output only with both blocks powered
   p_signal_needs_power_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (outs.aout == AOUT_SIG) |-> outs.dig && outs.ana);

   // R6: a driven output never appears without the analog block
   p_driven_needs_analog_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (outs.aout != AOUT_HIZ) |-> outs.ana && outs.ldo);

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
   import pwrmode_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int TIMEOUT_CYC  = 50,
   parameter int RESUME_EDGES = 4
) (
   input  logic       ref_clk,
   input  logic       pdn_n,
   input  logic       mclk,
   input  logic       ldo_keep,
   input  logic       pwr_en,
   input  logic       core_run,
   output logic       dig_en,
   output logic       ana_en,
   output logic       ldo_en,
   output logic       reg_en,
   output logic       iref_en,
   output logic       zdet_en,
   output logic [1:0] aout_mode
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwrmode_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic    rst_n;
   logic    tgl;
   logic    clk_lost;
   pm_out_t outs;

   pm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (ref_clk),
      .arst_n (pdn_n),
      .rst_n  (rst_n)
   );

   pm_mclk_toggle u_tgl (
      .mclk   (mclk),
      .arst_n (pdn_n),
      .tgl    (tgl)
   );

   pm_clk_watch #(
      .SYNC_STAGES  (SYNC_STAGES),
      .TIMEOUT_CYC  (TIMEOUT_CYC),
      .RESUME_EDGES (RESUME_EDGES)
   ) u_watch (
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .tgl_async (tgl),
      .clk_lost  (clk_lost)
   );

   pm_mode_ctrl u_mode (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .clk_lost (clk_lost),
      .pwr_en   (pwr_en),
      .core_run (core_run),
      .ldo_keep (ldo_keep),
      .outs     (outs)
   );

   assign dig_en    = outs.dig;
   assign ana_en    = outs.ana;
   assign ldo_en    = outs.ldo;
   assign reg_en    = outs.regf;
   assign iref_en   = outs.iref;
   assign zdet_en   = outs.zdet;
   assign aout_mode = outs.aout;

   // R1: the first cycle out of power-down still shows everything off
   p_powerup_starts_off_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dig_en && !ana_en && (aout_mode == 2'd0));

endmodule

// File: tb/sim_pwrmode_ctrl.sv
module sim_pwrmode_ctrl;
   localparam int TO  = 20;
   localparam int RES = 3;

   logic ref_clk = 1'b0;
   logic mclk = 1'b0;
   logic mclk_run = 1'b0;
   logic pdn_n = 1'b0;
   logic ldo_keep = 1'b0;
   logic pwr_en = 1'b0;
   logic core_run = 1'b0;
   logic dig_en, ana_en, ldo_en, reg_en, iref_en, zdet_en;
   logic [1:0] aout_mode;

   int vectors = 0;
   int fails = 0;

   pwrmode_ctrl #(.SYNC_STAGES(2), .TIMEOUT_CYC(TO), .RESUME_EDGES(RES)) u0 (
      .ref_clk(ref_clk), .pdn_n(pdn_n), .mclk(mclk), .ldo_keep(ldo_keep),
      .pwr_en(pwr_en), .core_run(core_run), .dig_en(dig_en), .ana_en(ana_en),
      .ldo_en(ldo_en), .reg_en(reg_en), .iref_en(iref_en), .zdet_en(zdet_en),
      .aout_mode(aout_mode)
   );

   always #10 ref_clk = ~ref_clk;

   initial forever begin
      #30;
      if (mclk_run) mclk = ~mclk;
   end

   function automatic logic [7:0] got_vec();
      return {dig_en, ana_en, ldo_en, reg_en, iref_en, zdet_en, aout_mode};
   endfunction

   // {dig, ana, ldo, reg, iref, zdet, mode}
   function automatic logic [7:0] exp_vec(logic pd, logic stopped, logic pw,
                                          logic cr, logic lk);
      if (!pd)      return 8'b000000_00;
      if (stopped)  return {2'b00, lk, 5'b000_00};
      if (!pw)      return 8'b001111_00;
      if (!cr)      return 8'b011111_01;
      return 8'b111111_10;
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic wait_ref(input int n);
      for (int k = 0; k < n; k++) @(negedge ref_clk);
   endtask

   task automatic pulse_mclk();
      mclk = 1'b1;
      #30;
      mclk = 1'b0;
      #30;
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int lat;
      // reset state (R1)
      wait_ref(3);
      chk("R1 reset", got_vec(), 8'h00);

      // exhaustive sweep: R1 R3 R4 R5 R6 R7
      for (int i = 0; i < 32; i++) begin
         logic pd, rn, pw, cr, lk;
         {pd, rn, pw, cr, lk} = 5'(i);
         pwr_en   = pw;
         core_run = cr;
         ldo_keep = lk;
         mclk_run = rn;
         pdn_n    = pd;
         wait_ref(pd ? 4 * TO : 5);
         if (!pd)        chk("R1 sweep", got_vec(), exp_vec(pd, !rn, pw, cr, lk));
         else if (!rn)   chk("R3/R4 sweep", got_vec(), exp_vec(pd, !rn, pw, cr, lk));
         else if (!pw)   chk("R5 sweep", got_vec(), exp_vec(pd, !rn, pw, cr, lk));
         else if (!cr)   chk("R6 sweep", got_vec(), exp_vec(pd, !rn, pw, cr, lk));
         else            chk("R7 sweep", got_vec(), exp_vec(pd, !rn, pw, cr, lk));
      end

      // asynchronous power-down (R1)
      pwr_en = 1'b1; core_run = 1'b1; ldo_keep = 1'b1; mclk_run = 1'b1;
      wait_ref(4 * TO);
      chk("R7 before pdn", got_vec(), 8'b111111_10);
      #3 pdn_n = 1'b0;
      #2 chk("R1 async", got_vec(), 8'h00);

      // start after pdn with no clock (R10)
      mclk_run = 1'b0;
      wait_ref(2);
      pdn_n = 1'b1;
      wait_ref(4 * TO);
      chk("R10 start stopped", got_vec(), exp_vec(1, 1, 1, 1, 1));

      // one edge short (R8)
      for (int k = 0; k < RES - 1; k++) pulse_mclk();
      wait_ref(10);
      chk("R8 short of edges", got_vec(), exp_vec(1, 1, 1, 1, 1));

      // gap then partial burst (R9)
      wait_ref(3 * TO);
      for (int k = 0; k < RES - 1; k++) pulse_mclk();
      wait_ref(10);
      chk("R9 gap discards count", got_vec(), exp_vec(1, 1, 1, 1, 1));
      pulse_mclk();
      wait_ref(10);
      chk("R8 resume without pdn", got_vec(), 8'b111111_10);

      // stop latency window (R2)
      mclk_run = 1'b1;
      wait_ref(4 * TO);
      chk("R2 running", got_vec(), 8'b111111_10);
      mclk_run = 1'b0;
      lat = 0;
      while (dig_en === 1'b1 && lat < 10 * TO) begin
         @(negedge ref_clk);
         lat++;
      end
      vectors++;
      if (lat < TO || lat > TO + 8) begin
         fails++;
         $display("FAIL R2 latency: got %0d expected %0d..%0d", lat, TO, TO + 8);
      end
      wait_ref(2);
      chk("R2 stopped", got_vec(), exp_vec(1, 1, 1, 1, 1));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule